// File: doc/BRIEF.md
# Fast-Serial Byte Transmitter

This block moves one byte from a peripheral to its host over the fast-serial path. SRQ is the bit strobe and DATA carries the bit value. Both lines are open-collector, so the block drives enables: a 1 on an enable pulls that line low.

A start strobe loads the byte and a two-bit flag field. The block then waits until the host's CLK line reaches the level the flags ask for. One flag bit selects that level and the other skips the wait entirely. Once the wait is satisfied, the block shifts the byte out MSB first, one SRQ pulse per bit.

ATN is watched the whole time the block is busy. If the host asserts ATN, the block drops both lines, ends the transfer and reports that attention was seen. A done pulse marks every ending, whether the byte completed or was aborted.

Top module: `fser_byte_tx`

## Requirements
- R1: During and after reset, srq_drv_o, data_drv_o, done_o and atn_seen_o are all 0.
- R2: flags_i[0] selects the CLK level awaited before sending: 1 waits for clk_line_i high (released), 0 waits for clk_line_i low (active). With flags_i[1] clear, no line is driven until that level is seen. Transmission starts on the first clock edge that samples the matching level.
- R3: When flags_i[1] is 1, the CLK level is not examined and transmission starts on the clock edge after the start strobe is accepted.
- R4: If atn_line_i is low (ATN asserted) on an edge while the block is waiting for CLK, the block ends at that edge. done_o then pulses with atn_seen_o = 1, and SRQ and DATA are never driven during that transfer. When ATN and a matching CLK arrive on the same edge, ATN wins.
- R5: If atn_line_i is low on an edge during shifting, both drive enables are released at that edge, and done_o pulses with atn_seen_o = 1.
- R6: atn_seen_o is 0 after a transfer that completes, and 1 after an aborted one. The value is held until the next accepted start, which clears it on the accepting edge.
- R7: Bits go out MSB first. A 1 bit leaves DATA released (data_drv_o = 0) and a 0 bit drives it (data_drv_o = 1). Each bit is presented one half-period before SRQ is driven, and it stays unchanged while SRQ is driven.
- R8: The byte produces exactly 8 SRQ pulses. Both the SRQ-driven phase and the SRQ-released phase last H = CLK_MHZ*HALF_US clock cycles.
- R9: After the eighth pulse, both lines are released and done_o is high for exactly one cycle. When the transfer starts on edge G, done_o rises on edge G+16H.
- R10: A start strobe that arrives while a transfer is in progress is ignored. The byte, the flags and the timing of the running transfer are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| byte_i | input | WIDTH | Byte to send |
| flags_i | input | 2 | Bit 0: awaited CLK level; bit 1: skip the CLK wait |
| atn_line_i | input | 1 | Synchronized ATN line level, low = asserted |
| clk_line_i | input | 1 | Synchronized CLK line level, high = released |
| srq_drv_o | output | 1 | SRQ pull-down enable |
| data_drv_o | output | 1 | DATA pull-down enable |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| atn_seen_o | output | 1 | 1 when the last transfer ended on ATN |

## Verification
The bench targets ATN arriving on the same edge as a matching CLK, at the very first wait cycle with the skip flag set, and in the middle of an SRQ pulse. A design that gave CLK priority over ATN, or that evaluated ATN only after the wait, would pulse SRQ or drive DATA when it should have aborted. CLK levels are given on both sides of each flag setting, with the matching level applied late. A design that inverted flag bit 0, or that ignored the skip flag, would start too early or too late and miss the expected done cycle. Pulse and gap widths, bit order and a second start strobe injected mid-byte are also measured. These catch a swapped bit order, an off-by-one half-period, and a transfer restarted by a stray strobe.

// File: rtl/fser_tx_pkg.sv
package fser_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  // clock cycles in one SRQ half-period
  function automatic int half_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  // pre-send gate: bypass bit, or CLK at the level named by bit 0
  function automatic logic clk_ready(input logic [1:0] fl, input logic clk_line);
    return fl[1] | (clk_line == fl[0]);
  endfunction

endpackage

// File: rtl/fser_half_timer.sv
module fser_half_timer #(
  parameter int HALF_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fser_bit_shifter.sv
module fser_bit_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             advance,
  output logic             cur_bit,
  output logic             last_bit
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

  logic [WIDTH-1:0] sh;
  logic [IW-1:0]    left;

  assign cur_bit  = sh[WIDTH-1];
  assign last_bit = (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= load_val;
      left <= TOP;
    end else if (advance) begin
      sh   <= sh << 1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/fser_byte_tx.sv
module fser_byte_tx
  import fser_tx_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int HALF_US = 4,
  parameter int WIDTH   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] byte_i,
  input  logic [1:0]       flags_i,
  input  logic             atn_line_i,
  input  logic             clk_line_i,
  output logic             srq_drv_o,
  output logic             data_drv_o,
  output logic             done_o,
  output logic             atn_seen_o
);
  localparam int HALF_CYC = half_cycles(CLK_MHZ, HALF_US);

  tx_state_e  state;
  logic [1:0] held_flags;
  logic       phase;     // 0: bit set up, SRQ released; 1: SRQ driven
  logic       done_q;
  logic       seen_q;

  // named events, also used by the checker
  logic busy, in_wait, in_shift, skip_flag, atn_active;
  logic accept, go_shift, abort_now, tick, strobe_end;
  logic cur_bit, last_bit, finish, adv;

  assign busy       = (state != ST_IDLE);
  assign in_wait    = (state == ST_WAIT);
  assign in_shift   = (state == ST_SHIFT);
  assign skip_flag  = held_flags[1];
  assign atn_active = ~atn_line_i;
  assign accept     = start_i && (state == ST_IDLE);
  assign abort_now  = busy && atn_active;
  assign go_shift   = in_wait && !atn_active && clk_ready(held_flags, clk_line_i);
  assign strobe_end = in_shift && tick && phase && !atn_active;
  assign finish     = strobe_end && last_bit;
  assign adv        = strobe_end && !last_bit;

  fser_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_shift),
    .tick  (tick)
  );

  fser_bit_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (byte_i),
    .advance  (adv),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      held_flags <= '0;
      phase      <= 1'b0;
      done_q     <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_WAIT;
            held_flags <= flags_i;
            seen_q     <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (abort_now) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            seen_q <= 1'b1;
          end else if (go_shift) begin
            state <= ST_SHIFT;
            phase <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (abort_now) begin
            state  <= ST_IDLE;
            phase  <= 1'b0;
            done_q <= 1'b1;
            seen_q <= 1'b1;
          end else if (tick) begin
            phase <= ~phase;
            if (finish) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign srq_drv_o  = in_shift & phase;
  assign data_drv_o = in_shift & ~cur_bit;
  assign done_o     = done_q;
  assign atn_seen_o = seen_q;

endmodule

// File: rtl/fser_byte_tx_chk.sv
module fser_byte_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       atn_line_i,
  input logic       srq_drv_o,
  input logic       data_drv_o,
  input logic       done_o,
  input logic       atn_seen_o,
  input logic       busy,
  input logic       in_wait,
  input logic       in_shift,
  input logic       skip_flag,
  input logic [1:0] held_flags
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!srq_drv_o && !data_drv_o)); // R9

  AST_WAIT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (!srq_drv_o && !data_drv_o)); // R2

  AST_SKIP_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && skip_flag && atn_line_i) |=> in_shift); // R3

  AST_ATN_WAIT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !atn_line_i) |=> (done_o && atn_seen_o && !busy)); // R4

  AST_ATN_SHIFT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && !atn_line_i) |=> (done_o && atn_seen_o && !srq_drv_o && !data_drv_o)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (srq_drv_o && $past(srq_drv_o)) |-> $stable(data_drv_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(held_flags)); // R10
endmodule

bind fser_byte_tx fser_byte_tx_chk u_chk (.*);

// File: tb/sim_fser_byte_tx.sv
module sim_fser_byte_tx;
  localparam int MHZ = 2;
  localparam int HUS = 4;
  localparam int H   = MHZ * HUS;

  typedef struct packed {
    logic [7:0] b;
    logic [1:0] fl;
    logic       ci;    // CLK line level at start
    int         flip;  // cycle at which CLK takes the awaited level (0: never)
    int         atn;   // cycle at which ATN is asserted (0: never)
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{8'hA5, 2'b01, 1'b1, 0,  0 },
    '{8'h3C, 2'b00, 1'b0, 0,  0 },
    '{8'h96, 2'b00, 1'b1, 5,  0 },
    '{8'h0F, 2'b01, 1'b0, 7,  0 },
    '{8'hF0, 2'b10, 1'b1, 0,  0 },
    '{8'h81, 2'b11, 1'b0, 0,  0 },
    '{8'h55, 2'b00, 1'b1, 0,  4 },
    '{8'hFF, 2'b01, 1'b1, 0,  40},
    '{8'h00, 2'b01, 1'b0, 20, 10},
    '{8'hC3, 2'b10, 1'b0, 0,  1 }
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [1:0] flags_in = 2'b00;
  logic       atn_line = 1'b1;
  logic       clk_line = 1'b1;
  logic       srq_drv_o, data_drv_o, done_o, atn_seen_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fser_byte_tx #(.CLK_MHZ(MHZ), .HALF_US(HUS), .WIDTH(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .byte_i     (byte_in),
    .flags_i    (flags_in),
    .atn_line_i (atn_line),
    .clk_line_i (clk_line),
    .srq_drv_o  (srq_drv_o),
    .data_drv_o (data_drv_o),
    .done_o     (done_o),
    .atn_seen_o (atn_seen_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected number of SRQ pulses given go edge g and ATN cycle a
  function automatic int exp_pulses(input int g, input int a);
    int n = 0;
    if (a == 0) return 8;
    if (a <= g) return 0;
    for (int k = 0; k < 8; k++)
      if (g + H + 2*H*k < a) n++;
    return n;
  endfunction

  task automatic run_vec(input vec_t v, input int extra);
    int c = 0, g, done_c = 0, pulses = 0, last_rise = 0, last_fall = 0;
    int ep, ec;
    bit fin = 0, drove = 0, prev_srq = 0, abort;
    logic [7:0] rcv = 8'h00;
    g     = (v.flip == 0) ? 1 : v.flip;
    ep    = exp_pulses(g, v.atn);
    abort = (v.atn != 0) && (v.atn <= g + 16*H);
    ec    = abort ? v.atn + 1 : g + 1 + 16*H;
    @(negedge clk);
    clk_line = v.ci;
    atn_line = 1'b1;
    byte_in  = v.b;
    flags_in = v.fl;
    start    = 1'b1;
    while (!fin && c < 2000) begin
      @(negedge clk);
      c++;
      if (c == 1) chk(atn_seen_o == 1'b0, "R6", "result cleared on start", atn_seen_o, 0);
      if (done_o) begin fin = 1; done_c = c; end
      if (srq_drv_o && !prev_srq) begin
        pulses++;
        rcv = {rcv[6:0], ~data_drv_o};
        if (pulses == 1)
          chk(c == g + 1 + H, "R7", "bit set-up before first strobe", c, g + 1 + H);
        else
          chk(c - last_fall == H, "R8", "SRQ released width", c - last_fall, H);
        last_rise = c;
      end
      if (!srq_drv_o && prev_srq && !(abort && done_o)) begin
        chk(c - last_rise == H, "R8", "SRQ driven width", c - last_rise, H);
        last_fall = c;
      end
      if (srq_drv_o || data_drv_o) drove = 1;
      prev_srq = srq_drv_o;
      start = (extra != 0 && c == extra);
      if (extra != 0 && c == extra) begin
        byte_in  = ~v.b;
        flags_in = 2'b10;
      end
      if (v.flip != 0 && c == v.flip) clk_line = v.fl[0];
      if (v.atn != 0 && c == v.atn) atn_line = 1'b0;
    end
    chk(fin, "R9", "done seen", fin, 1);
    chk(done_c == ec, "R2 R3 R9", "done cycle", done_c, ec);
    chk(atn_seen_o == abort, "R4 R5 R6", "attention result", atn_seen_o, abort);
    chk(pulses == ep, "R8", "SRQ pulse count", pulses, ep);
    if (!abort) chk(rcv == v.b, "R7", "received byte", rcv, v.b);
    if (abort && ep == 0) chk(!drove, "R4", "lines untouched on wait abort", drove, 0);
    start = 1'b0;
    atn_line = 1'b1;
    @(negedge clk);
    chk(!done_o && !srq_drv_o && !data_drv_o, "R9", "one-cycle done, lines released",
        {done_o, srq_drv_o, data_drv_o}, 0);
    if (abort) begin
      repeat (3) @(negedge clk);
      chk(atn_seen_o == 1'b1, "R6", "attention result held", atn_seen_o, 1);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!srq_drv_o && !data_drv_o && !done_o && !atn_seen_o, "R1", "outputs in reset",
        {srq_drv_o, data_drv_o, done_o, atn_seen_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!srq_drv_o && !data_drv_o && !done_o && !atn_seen_o, "R1", "outputs after reset",
        {srq_drv_o, data_drv_o, done_o, atn_seen_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], 0);

    // R10: second strobe mid-byte must not disturb the transfer
    run_vec('{8'h5A, 2'b01, 1'b1, 0, 0}, 50);
    // R3: skip with CLK at the opposite level of bit 0
    run_vec('{8'h69, 2'b11, 1'b0, 0, 0}, 0);
    // R4: ATN on the same edge as a matching CLK wins
    run_vec('{8'h24, 2'b01, 1'b0, 6, 6}, 0);
    // R5: ATN in the middle of an SRQ pulse
    run_vec('{8'hE7, 2'b00, 1'b0, 0, 13}, 0);

    summary();
    $finish;
  end
endmodule